// File: doc/BRIEF.md
# Variable-Depth Pretrigger Delay FIFO

This block is a streaming delay line for a capture path. Every accepted input sample is stored, and the sample that arrived a programmable number of valid beats earlier is sent out. A capture buffer placed after it therefore also holds the history that came before a trigger event. The delay is counted in valid beats, not in clock cycles, so the block works the same way when an upstream decimator leaves gaps in the stream.

The storage sits outside the block. The block drives a simple dual-port block RAM through separate write and read ports. That RAM must have a one-cycle registered read and must return the old contents when a read and a write hit the same address in the same cycle. The block itself manages the write pointer, derives the read address from the depth, and tracks how many entries have been filled. A depth of zero bypasses the RAM. Any change of the depth setting restarts the delay line.

Top module: `pretrig_delay_fifo`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `out_valid` is low and `ram_wr_addr` is 0.
- R2: The storage length is 2**`ADDR_W` entries. With the default `ADDR_W` = 13 this is 8192, and addresses wrap modulo this length.
- R3: Each accepted valid beat writes `in_data` to the RAM once, at consecutive wrapping addresses. The read address is the write address minus the effective depth, modulo the length.
- R4: With an effective depth of 0, `ram_wr_en` stays low and each accepted sample is sent out unchanged.
- R5: An accepted beat that produces output shows `out_valid` high exactly 2 clock cycles after its input cycle, in bypass and in delay mode alike.
- R6: With gaps in `in_valid`, `out_valid` pulses once per producing beat at the 2-cycle position and is low otherwise. Order is kept and no sample is dropped or repeated.
- R7: After reset or a depth change, the first D accepted beats produce no output. Beat n (counting from 0) with n ≥ D outputs the data of beat n−D.
- R8: In a cycle where `depth` differs from its previous-cycle value, the pointers and the fill count restart, the beat offered in that cycle is discarded, and `out_valid` is low in the two following cycles.
- R9: A depth above the storage length acts as a depth equal to the length.
- R10: With a depth equal to the length, the read and write addresses coincide, and the output is the entry written exactly one length earlier (read-before-write RAM).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Input sample |
| in_valid | input | 1 | Input sample strobe |
| depth | input | ADDR_W+1 | Delay in valid beats; 0 selects bypass |
| out_data | output | DATA_W | Delayed sample |
| out_valid | output | 1 | Delayed sample strobe |
| ram_wr_addr | output | ADDR_W | RAM write address |
| ram_wr_en | output | 1 | RAM write enable |
| ram_wr_data | output | DATA_W | RAM write data |
| ram_rd_addr | output | ADDR_W | RAM read address |
| ram_rd_data | input | DATA_W | RAM read data, one cycle after the address |

## Verification
Two events can land in the same cycle: a depth change and a valid input beat. That beat must be discarded while the pointers restart, and the outputs of beats already in flight must be suppressed. The bench provokes this by changing the depth on a cycle that carries a valid beat, both in a continuous stream and in a gapped one. The behavioural queue model then predicts which beats vanish and when output resumes. Each depth change is also followed by a full wrap of the write address at the maximum depth and at a clamped depth.

// File: rtl/pretrig_delay_fifo.sv
module pretrig_delay_fifo #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic [ADDR_W:0]   depth,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic [ADDR_W-1:0] ram_wr_addr,
  output logic              ram_wr_en,
  output logic [DATA_W-1:0] ram_wr_data,
  output logic [ADDR_W-1:0] ram_rd_addr,
  input  logic [DATA_W-1:0] ram_rd_data
);

  localparam logic [ADDR_W:0] LEN = {1'b1, {ADDR_W{1'b0}}};

  logic [ADDR_W:0]   depth_q, depth_eff, fill;
  logic [ADDR_W-1:0] wr_ptr;
  logic              chg, byp, full, acc;
  logic              p1_v, p1_byp;
  logic [DATA_W-1:0] p1_d;

  assign depth_eff   = (depth_q > LEN) ? LEN : depth_q;
  assign chg         = depth != depth_q;
  assign byp         = depth_eff == '0;
  assign full        = fill == depth_eff;
  assign acc         = in_valid && !chg;

  assign ram_wr_en   = acc && !byp;
  assign ram_wr_addr = wr_ptr;
  assign ram_wr_data = in_data;
  assign ram_rd_addr = wr_ptr - depth_eff[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q   <= depth;
      wr_ptr    <= '0;
      fill      <= '0;
      p1_v      <= 1'b0;
      p1_byp    <= 1'b0;
      p1_d      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      depth_q <= depth;
      if (chg) begin
        wr_ptr <= '0;
        fill   <= '0;
      end else if (in_valid) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (!full) fill <= fill + 1'b1;
      end
      p1_v   <= acc && full;
      p1_byp <= byp;
      if (acc) p1_d <= in_data;
      out_valid <= p1_v && !chg;
      if (p1_v) out_data <= p1_byp ? p1_d : ram_rd_data;
    end
  end

endmodule

module pretrig_delay_fifo_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [ADDR_W:0]   depth,
  input logic              out_valid,
  input logic [ADDR_W-1:0] ram_wr_addr,
  input logic              ram_wr_en
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !out_valid);

  p_latency_two_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  p_change_flush_r8: assert property (@(posedge clk) disable iff (rst)
    (depth != $past(depth)) |=> !out_valid);

  p_change_flush2_r8: assert property (@(posedge clk) disable iff (rst)
    (depth != $past(depth)) |-> ##2 !out_valid);

  p_bypass_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (depth == '0 && $past(depth) == '0) |-> !ram_wr_en);

  p_write_step_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(ram_wr_en) && !$past(rst) && depth == $past(depth))
      |-> ram_wr_addr == ADDR_W'($past(ram_wr_addr) + 1'b1));

endmodule

bind pretrig_delay_fifo pretrig_delay_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/pretrig_delay_fifo_tb_top.sv
`timescale 1ns/1ps
module pretrig_delay_fifo_tb_top;
  localparam int DW = 16;
  localparam int AW = 13;
  localparam int LEN = 1 << AW;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [DW-1:0] in_data = '0;
  logic [AW:0]   depth = '0;
  logic [DW-1:0] out_data, ram_wr_data, ram_rd_data;
  logic          out_valid, ram_wr_en;
  logic [AW-1:0] ram_wr_addr, ram_rd_addr;

  always #2.5 clk = ~clk;

  pretrig_delay_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .depth(depth),
    .out_data(out_data), .out_valid(out_valid), .ram_wr_addr(ram_wr_addr),
    .ram_wr_en(ram_wr_en), .ram_wr_data(ram_wr_data), .ram_rd_addr(ram_rd_addr),
    .ram_rd_data(ram_rd_data));

  // read-before-write RAM with registered read
  logic [DW-1:0] mem [LEN];
  always @(posedge clk) begin
    ram_rd_data <= mem[ram_rd_addr];
    if (ram_wr_en) mem[ram_wr_addr] <= ram_wr_data;
  end

  // behavioural reference
  int unsigned   m_dq, m_n;
  logic [DW-1:0] hist [int];
  logic          m_p1v = 0, m_ov = 0;
  logic [DW-1:0] m_p1d = '0, m_od = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_dq = depth; m_n = 0; hist.delete(); m_p1v = 0; m_ov = 0;
    end else begin
      int unsigned d_eff;
      m_ov = m_p1v && (depth == m_dq);
      if (m_p1v) m_od = m_p1d;
      if (depth != m_dq) begin
        m_dq = depth; m_n = 0; hist.delete(); m_p1v = 0;
      end else begin
        d_eff = (m_dq > LEN) ? LEN : m_dq;
        m_p1v = 0;
        if (in_valid) begin
          hist[m_n] = in_data;
          if (m_n >= d_eff) begin
            m_p1v = 1;
            m_p1d = hist[m_n - d_eff];
            hist.delete(m_n - d_eff);
          end
          m_n++;
        end
      end
    end
  end

  int checks = 0, errors = 0;
  string req = "R1";
  logic [DW-1:0] dcnt = '0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    if (!rst) begin
      chk(out_valid == m_ov, "out_valid", out_valid, m_ov);
      if (m_ov && out_valid) chk(out_data == m_od, "out_data", out_data, m_od);
      if (ram_wr_en) chk(ram_wr_data == in_data, "ram_wr_data R3", ram_wr_data, in_data);
      if (depth == 0 && m_dq == 0) chk(ram_wr_en == 0, "bypass write R4", ram_wr_en, 0);
    end
  endtask

  task automatic step(input bit v, input int dep);
    @(negedge clk);
    check_outputs();
    depth    = dep[AW:0];
    in_valid = v;
    in_data  = dcnt;
    if (v) dcnt++;
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R1";
    chk(out_valid == 0, "reset out_valid", out_valid, 0);
    chk(ram_wr_addr == 0, "reset wr addr", ram_wr_addr, 0);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0, "post-reset out_valid", out_valid, 0);
    chk(ram_wr_addr == 0, "post-reset wr addr", ram_wr_addr, 0);
    req = "R4 R5";
    for (int i = 0; i < 20; i++) step(1, 0);
    req = "R8 R7";
    for (int i = 0; i < 40; i++) step(1, 5);
    req = "R6";
    for (int i = 0; i < 80; i++) step(($urandom % 3) != 0, 5);
    req = "R8";
    for (int i = 0; i < 30; i++) step(1, 3);
    for (int i = 0; i < 40; i++) step(($urandom % 2) != 0, (i < 20) ? 3 : 6);
    req = "R10 R2";
    for (int i = 0; i < 8400; i++) step((i < 8200) || (($urandom % 3) != 0), LEN);
    req = "R9 R2";
    for (int i = 0; i < 8400; i++) step(1, 9000);
    req = "R6 R3";
    for (int i = 0; i < 100; i++) step(($urandom % 3) == 0, 1);
    req = "R4";
    for (int i = 0; i < 50; i++) step(($urandom % 2) != 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule